// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block gives a processor core a small set of hardware counters for profiling. One counter advances on every clock of the core. Four more counters each advance when their own event strobe pulses. Software reaches every counter through a single-cycle register port. It can preload any counter, zero the cycle counter or the whole event group through a control register, and stop or start all counting with a global enable bit.

When a counter steps past its all-ones value, it returns to zero and latches a sticky overflow flag of its own. Software clears a flag by writing a one to its bit. A per-flag enable mask selects which flags drive the single interrupt line. That line is a level: it stays high as long as any enabled flag is still set. Software can therefore use a preload near the top of the range to get an interrupt after a chosen number of cycles or events.

Register map (word index on `reg_addr_i`):

| Index | Register |
|---|---|
| 0 | control |
| 1 | overflow flags |
| 2 | interrupt enables |
| 3 | cycle counter |
| 4 + i | event counter i |

Reads are combinational from `reg_addr_i`. A write happens on the rising clock edge when `reg_wr_i` is high.

Top module: `pmu_top`

## Requirements
- R1: While reset is asserted and right after it, every counter, the overflow flags, the interrupt enables and the global enable read as zero, and `irq_o` is low.
- R2: The cycle counter (index 3) adds one on each clock edge at which the global enable is 1. It holds its value while the enable is 0. The enable is bit 0 of the control register (index 0). A write to the enable takes effect from the following edge.
- R3: Event counter i (index 4+i) adds one on each clock edge at which `evt_i[i]` is high and the global enable is 1. Otherwise it holds its value.
- R4: A control write with bit 2 set zeroes the cycle counter. A control write with bit 1 set zeroes all event counters. These two bits are not stored: the control register reads back as zero except for bit 0, which holds the enable.
- R5: A write to a counter's index loads the written value at that edge. The load replaces any increment in that cycle. A clear or a load never produces a wrap in that cycle.
- R6: A cycle counter at 0xFFFFFFFF that is incremented becomes 0 and sets overflow flag bit 0.
- R7: An event counter i at 0xFFFFFFFF that counts an event becomes 0 and sets overflow flag bit i+1.
- R8: The overflow flags (index 1, bits 4:0) are write-1-to-clear, and writing 0 to a bit leaves it unchanged. A wrap in the same cycle as a clear of that bit leaves the bit set.
- R9: The interrupt enables are bits 4:0 at index 2. `irq_o` is high exactly while some flag bit and its enable bit at the same position are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| evt_i | input | 4 | Event strobes, one per event counter |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench preloads counters just below the all-ones value, so that wraps happen often. It checks that a wrap sets only its own flag bit. A design with a shifted flag index would raise the wrong bit, and one that wraps on a load would set flags spuriously. It lines up a flag clear with a wrap on the same edge: a design that gives the clear priority would lose the overflow. It also writes the enable bit together with the clear bits and checks that the new enable only counts from the next edge, and that a load in a cycle with a pending increment keeps the loaded value exactly. An off-by-one in any of these shows up as a counter value mismatch on the very next clock.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  // Word indices of the register map
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_FLAG = 1;
  localparam int unsigned A_IEN  = 2;
  localparam int unsigned A_CYC  = 3;
  localparam int unsigned A_EVT0 = 4;

  // Control register bit positions
  localparam int unsigned CTRL_EN      = 0;
  localparam int unsigned CTRL_CLR_EVT = 1;
  localparam int unsigned CTRL_CLR_CYC = 2;

  function automatic int unsigned addr_bits(input int unsigned n_evt);
    return $clog2(A_EVT0 + n_evt);
  endfunction

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic         at_max;

  assign at_max = &cnt_q;
  assign cnt_en = clr_i | ld_i | inc_i;

  // Priority: clear, then load, then increment
  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (ld_i) begin
      cnt_d = ld_val_i;
    end else if (inc_i) begin
      cnt_d  = cnt_q + 1'b1;
      wrap_o = at_max;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pmu_flags.sv
module pmu_flags #(
  parameter int unsigned NF = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] wrap_i,
  input  logic          clr_wr_i,
  input  logic [NF-1:0] clr_mask_i,
  input  logic [NF-1:0] ien_i,
  output logic [NF-1:0] flag_o,
  output logic          irq_o
);

  logic [NF-1:0] flag_q;
  logic [NF-1:0] flag_d;
  logic [NF-1:0] kill;
  logic          flag_en;

  assign kill    = clr_wr_i ? clr_mask_i : '0;
  assign flag_en = clr_wr_i | (|wrap_i);

  // A wrap sets its bit even when the same bit is being cleared
  always_comb begin
    flag_d = (flag_q & ~kill) | wrap_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & ien_i);

endmodule

// File: rtl/pmu_regif.sv
module pmu_regif
  import pmu_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned N_EVT = 4,
  parameter int unsigned AW    = 3,
  parameter int unsigned NF    = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [W-1:0]              wdata_i,
  input  logic [W-1:0]              cyc_cnt_i,
  input  logic [N_EVT-1:0][W-1:0]   evt_cnt_i,
  input  logic [NF-1:0]             flag_i,
  output logic                      en_o,
  output logic [NF-1:0]             ien_o,
  output logic                      clr_cyc_o,
  output logic                      clr_evt_o,
  output logic                      ld_cyc_o,
  output logic [N_EVT-1:0]          ld_evt_o,
  output logic                      flag_wr_o,
  output logic [NF-1:0]             flag_mask_o,
  output logic [W-1:0]              rdata_o
);

  localparam logic [AW-1:0] ADR_CTRL = AW'(A_CTRL);
  localparam logic [AW-1:0] ADR_FLAG = AW'(A_FLAG);
  localparam logic [AW-1:0] ADR_IEN  = AW'(A_IEN);
  localparam logic [AW-1:0] ADR_CYC  = AW'(A_CYC);

  logic          sel_ctrl;
  logic          sel_ien;
  logic          en_q;
  logic          en_d;
  logic [NF-1:0] ien_q;
  logic [NF-1:0] ien_d;

  // Write decode
  assign sel_ctrl    = wr_i && (addr_i == ADR_CTRL);
  assign sel_ien     = wr_i && (addr_i == ADR_IEN);
  assign clr_cyc_o   = sel_ctrl && wdata_i[CTRL_CLR_CYC];
  assign clr_evt_o   = sel_ctrl && wdata_i[CTRL_CLR_EVT];
  assign ld_cyc_o    = wr_i && (addr_i == ADR_CYC);
  assign flag_wr_o   = wr_i && (addr_i == ADR_FLAG);
  assign flag_mask_o = wdata_i[NF-1:0];

  for (genvar gi = 0; gi < N_EVT; gi++) begin : g_ld
    assign ld_evt_o[gi] = wr_i && (addr_i == AW'(A_EVT0 + gi));
  end

  // Stored control state
  always_comb begin
    en_d  = sel_ctrl ? wdata_i[CTRL_EN] : en_q;
    ien_d = sel_ien ? wdata_i[NF-1:0] : ien_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else if (sel_ctrl) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
    end else if (sel_ien) begin
      ien_q <= ien_d;
    end
  end

  assign en_o  = en_q;
  assign ien_o = ien_q;

  // Read mux
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADR_CTRL) begin
      rdata_o = {{(W-1){1'b0}}, en_q};
    end else if (addr_i == ADR_FLAG) begin
      rdata_o = W'(flag_i);
    end else if (addr_i == ADR_IEN) begin
      rdata_o = W'(ien_q);
    end else if (addr_i == ADR_CYC) begin
      rdata_o = cyc_cnt_i;
    end else begin
      for (int i = 0; i < N_EVT; i++) begin
        if (addr_i == AW'(A_EVT0 + i)) begin
          rdata_o = evt_cnt_i[i];
        end
      end
    end
  end

endmodule

// File: rtl/pmu_top.sv
module pmu_top
  import pmu_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N_EVT = 4,
  localparam int unsigned AW   = addr_bits(N_EVT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  input  logic [N_EVT-1:0] evt_i,
  output logic             irq_o
);

  localparam int unsigned NF = N_EVT + 1;

  logic                         glb_en;
  logic [NF-1:0]                irq_en;
  logic                         clr_cyc;
  logic                         clr_evt;
  logic                         ld_cyc;
  logic [N_EVT-1:0]             ld_evt;
  logic                         flag_wr;
  logic [NF-1:0]                flag_mask;
  logic [NF-1:0]                ovf_flags;
  logic [NF-1:0]                wraps;
  logic [CNT_W-1:0]             cyc_cnt;
  logic [N_EVT-1:0][CNT_W-1:0]  evt_cnt;

  pmu_regif #(
    .W     (CNT_W),
    .N_EVT (N_EVT),
    .AW    (AW),
    .NF    (NF)
  ) u_regif (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .cyc_cnt_i   (cyc_cnt),
    .evt_cnt_i   (evt_cnt),
    .flag_i      (ovf_flags),
    .en_o        (glb_en),
    .ien_o       (irq_en),
    .clr_cyc_o   (clr_cyc),
    .clr_evt_o   (clr_evt),
    .ld_cyc_o    (ld_cyc),
    .ld_evt_o    (ld_evt),
    .flag_wr_o   (flag_wr),
    .flag_mask_o (flag_mask),
    .rdata_o     (reg_rdata_o)
  );

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_cyc),
    .ld_i     (ld_cyc),
    .ld_val_i (reg_wdata_i),
    .inc_i    (glb_en),
    .cnt_o    (cyc_cnt),
    .wrap_o   (wraps[0])
  );

  for (genvar gi = 0; gi < N_EVT; gi++) begin : g_evt
    pmu_counter #(.W(CNT_W)) u_evt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr_evt),
      .ld_i     (ld_evt[gi]),
      .ld_val_i (reg_wdata_i),
      .inc_i    (glb_en & evt_i[gi]),
      .cnt_o    (evt_cnt[gi]),
      .wrap_o   (wraps[gi+1])
    );
  end

  pmu_flags #(.NF(NF)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wrap_i     (wraps),
    .clr_wr_i   (flag_wr),
    .clr_mask_i (flag_mask),
    .ien_i      (irq_en),
    .flag_o     (ovf_flags),
    .irq_o      (irq_o)
  );

endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N_EVT = 4,
  parameter int unsigned AW    = 3
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        reg_wr_i,
  input logic [AW-1:0]               reg_addr_i,
  input logic [CNT_W-1:0]            reg_wdata_i,
  input logic [N_EVT-1:0]            evt_i,
  input logic                        irq_o,
  input logic                        en_q,
  input logic [CNT_W-1:0]            cyc_q,
  input logic [N_EVT-1:0][CNT_W-1:0] evt_q,
  input logic [N_EVT:0]              flag_q
);

  localparam logic [AW-1:0] ADR_CTRL = AW'(A_CTRL);
  localparam logic [AW-1:0] ADR_FLAG = AW'(A_FLAG);
  localparam logic [AW-1:0] ADR_CYC  = AW'(A_CYC);

  a_r2_cycle_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !(reg_wr_i && (reg_addr_i == ADR_CYC || reg_addr_i == ADR_CTRL)))
      |=> (cyc_q == CNT_W'($past(cyc_q) + 1'b1)));

  a_r2_cycle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !reg_wr_i) |=> $stable(cyc_q));

  for (genvar gi = 0; gi < N_EVT; gi++) begin : g_chk
    a_r3_event_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(en_q && evt_i[gi]) && !reg_wr_i) |=> $stable(evt_q[gi]));
  end

  a_r4_cycle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADR_CTRL && reg_wdata_i[CTRL_CLR_CYC]) |=> (cyc_q == '0));

  a_r6_cycle_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && (&cyc_q) && !reg_wr_i) |=> flag_q[0]);

  a_r8_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == ADR_FLAG) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  a_r9_irq_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !reg_wr_i) |=> irq_o);

endmodule

bind pmu_top pmu_checker #(
  .CNT_W (CNT_W),
  .N_EVT (N_EVT),
  .AW    (AW)
) u_pmu_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .evt_i       (evt_i),
  .irq_o       (irq_o),
  .en_q        (glb_en),
  .cyc_q       (cyc_cnt),
  .evt_q       (evt_cnt),
  .flag_q      (ovf_flags)
);

// File: tb/pmu_top_test.sv
module pmu_top_test;

  logic        clk;
  logic        rst_n;
  logic        wr;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  evt;
  logic        irq;

  int n_chk;
  int n_bad;
  bit done;

  pmu_top uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .evt_i       (evt),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  logic [31:0] m_cyc;
  logic [31:0] m_evt [4];
  logic [4:0]  m_flag;
  logic [4:0]  m_ien;
  logic        m_en;
  logic [4:0]  m_wrap;
  bit          m_clr_c;
  bit          m_clr_e;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_flag = 0; m_ien = 0; m_en = 0;
      for (int i = 0; i < 4; i++) m_evt[i] = 0;
    end else begin
      m_wrap  = 0;
      m_clr_c = wr && addr == 0 && wdata[2];
      m_clr_e = wr && addr == 0 && wdata[1];
      if (m_clr_c) m_cyc = 0;
      else if (wr && addr == 3) m_cyc = wdata;
      else if (m_en) begin
        if (m_cyc == 32'hFFFF_FFFF) m_wrap[0] = 1'b1;
        m_cyc = m_cyc + 1;
      end
      for (int i = 0; i < 4; i++) begin
        if (m_clr_e) m_evt[i] = 0;
        else if (wr && addr == 4 + i) m_evt[i] = wdata;
        else if (m_en && evt[i]) begin
          if (m_evt[i] == 32'hFFFF_FFFF) m_wrap[i+1] = 1'b1;
          m_evt[i] = m_evt[i] + 1;
        end
      end
      if (wr && addr == 1) m_flag = m_flag & ~wdata[4:0];
      m_flag = m_flag | m_wrap;
      if (wr && addr == 2) m_ien = wdata[4:0];
      if (wr && addr == 0) m_en = wdata[0];
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0:    return {31'b0, m_en};
      3'd1:    return {27'b0, m_flag};
      3'd2:    return {27'b0, m_ien};
      3'd3:    return m_cyc;
      default: return m_evt[a - 4];
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0:    return "R4";
      3'd1:    return "R8";
      3'd2:    return "R9";
      3'd3:    return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(tag_of(addr), rdata, m_read(addr));
      chk("R9 irq", {31'b0, irq}, {31'b0, |(m_flag & m_ien)});
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input logic w, input logic [2:0] a, input logic [31:0] d, input logic [3:0] e);
    @(negedge clk);
    #1;
    wr = w; addr = a; wdata = d; evt = e;
  endtask

  task automatic idle(input logic [2:0] a);
    drive(1'b0, a, 32'h0, 4'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; wr = 0; addr = 0; wdata = 0; evt = 0;
    repeat (3) @(posedge clk);
    // R1: everything reads zero under reset
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      #1;
      chk("R1 reset value", rdata, 32'h0);
    end
    chk("R1 irq low", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3'd3);
    idle(3'd3);
    @(negedge clk);
    chk("R2 counter stays with enable off", rdata, 32'h0);

    // R2: enable and let the cycle counter run
    drive(1'b1, 3'd0, 32'h1, 4'h0);
    repeat (10) idle(3'd3);

    // R3: event pulses with reads of each counter
    for (int k = 0; k < 40; k++) drive(1'b0, 3'(4 + (k % 4)), 32'h0, 4'(k * 7));

    // R6: cycle wrap, enable off while loading
    drive(1'b1, 3'd0, 32'h0, 4'h0);
    drive(1'b1, 3'd3, 32'hFFFF_FFFE, 4'h0);
    drive(1'b1, 3'd0, 32'h1, 4'h0);
    idle(3'd3);
    idle(3'd1);
    @(negedge clk);
    chk("R6 cycle wrap sets flag bit 0", rdata, 32'h1);

    // R7: event 2 wrap sets flag bit 3
    drive(1'b1, 3'd6, 32'hFFFF_FFFF, 4'h0);
    drive(1'b0, 3'd1, 32'h0, 4'b0100);
    @(negedge clk);
    chk("R7 event 2 wrap sets flag bit 3", rdata, 32'h9);

    // R9: enable interrupt for bit 3
    drive(1'b1, 3'd2, 32'h8, 4'h0);
    idle(3'd1);
    @(negedge clk);
    chk("R9 irq raised", {31'b0, irq}, 32'h1);

    // R8: writing zero leaves flags, writing one clears
    drive(1'b1, 3'd1, 32'h0, 4'h0);
    idle(3'd1);
    @(negedge clk);
    chk("R8 zero write keeps flags", rdata, 32'h9);
    drive(1'b1, 3'd1, 32'h8, 4'h0);
    idle(3'd1);
    @(negedge clk);
    chk("R8 one write clears bit 3", rdata, 32'h1);
    chk("R9 irq dropped", {31'b0, irq}, 32'h0);

    // R8: wrap in the same cycle as a clear keeps the flag
    drive(1'b1, 3'd3, 32'hFFFF_FFFE, 4'h0);
    idle(3'd1);
    drive(1'b1, 3'd1, 32'h1, 4'h0);
    @(negedge clk);
    chk("R8 wrap wins over clear", rdata & 32'h1, 32'h1);

    // R5: load overrides an increment on event 0
    drive(1'b1, 3'd4, 32'd123, 4'h1);
    idle(3'd4);
    @(negedge clk);
    chk("R5 load replaces increment", rdata, 32'd123);

    // R5: load of all ones does not set a flag
    drive(1'b1, 3'd1, 32'h1F, 4'h0);
    drive(1'b1, 3'd5, 32'hFFFF_FFFF, 4'h0);
    idle(3'd1);
    @(negedge clk);
    chk("R5 load gives no wrap", rdata, 32'h0);

    // R4: clears together with enable, events pulsing
    drive(1'b1, 3'd0, 32'h7, 4'hF);
    idle(3'd3);
    drive(1'b1, 3'd0, 32'h3, 4'hF);
    idle(3'd0);
    @(negedge clk);
    chk("R4 control reads only enable", rdata, 32'h1);
    drive(1'b1, 3'd0, 32'h4, 4'h0);
    idle(3'd3);
    @(negedge clk);
    chk("R4 clear with enable off leaves zero", rdata, 32'h0);
    drive(1'b1, 3'd0, 32'h1, 4'h0);
    drive(1'b1, 3'd2, 32'h1F, 4'h0);

    // random traffic, biased toward wraps
    for (int k = 0; k < 3000; k++) begin
      automatic logic        w = ($urandom_range(0, 4) == 0);
      automatic logic [2:0]  a = 3'($urandom_range(0, 7));
      automatic logic [31:0] d = $urandom;
      if (a == 3'd0) d = {29'b0, ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0),
                          ($urandom_range(0, 9) != 0)};
      else if (a >= 3'd3 && $urandom_range(0, 1) == 1) d = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
      drive(w, a, d, 4'($urandom));
    end
    idle(3'd1);
    @(negedge clk);
    finish_run();
  end

endmodule